// File: doc/BRIEF.md
# Carry-Select Adder with Lookahead Sections

This block adds two unsigned words and a carry input in one combinational pass, returning a word-wide sum and a carry output. The word is cut into equal sections (4 bits by default). Inside each section every carry is formed directly from per-bit generate (`a AND b`) and propagate (`a XOR b`) terms as a flattened sum of products, so nothing ripples inside a section.

The lowest section takes the external carry input straight into its lookahead equations. Every section above it holds two lookahead copies, one evaluated with an assumed carry-in of 0 and one with 1, both working in parallel with the sections below. When the true carry arrives from the section underneath, a multiplexer picks the matching sum bits and carry-out, and that chosen carry-out selects the next section up. The carry-out of the top section is the block's carry output. The block has no clock, no registers, no handshake and no signed or overflow interpretation; it is meant to sit inside a datapath (for example the accumulate step of an iterative multiplier) where its result is consumed in the same cycle.

Top module: `csla_adder`

## Requirements
- R1: For every input, `{c_out, sum_out}` equals `a_in + b_in + c_in` computed on WIDTH+1 bits, with `c_out` as bit WIDTH.
- R2: The lowest section uses `c_in` directly: with `a_in = b_in = 0`, `sum_out` equals `c_in` (bit 0) and `c_out` is 0.
- R3: A carry entering at bit 0 propagates through every section: all-ones plus zero plus `c_in = 1` gives `sum_out = 0` and `c_out = 1`.
- R4: Each upper section delivers the candidate matching its true incoming carry: `0x0000000F + 0x00000001` gives `0x00000010`, and `0x0FFFFFFF + 0x00000001` gives `0x10000000`, both with `c_out = 0`.
- R5: A section that generates its own carry passes it upward whatever the incoming carry: `0x000000F0 + 0x00000010 + 1` gives `0x00000101`, and `0x80000000 + 0x80000000` gives `sum_out = 0` with `c_out = 1`.
- R6: Alternating patterns sum correctly: `0xAAAAAAAA + 0x55555555` gives `0xFFFFFFFF` with `c_out = 0` for `c_in = 0`, and `0x00000000` with `c_out = 1` for `c_in = 1`.
- R7: The width and section size are parameters (WIDTH a multiple of GRP); an 8-bit, 4-bit-section build meets R1 for all 2^17 input combinations.
- R8: The block is purely combinational: outputs follow inputs within the same time step, with no clock or reset port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| c_out | output | 1 | Carry out of the top bit |

## Verification
The two functions that meet in one evaluation are a section generating its own carry internally and the same section receiving a carry from below that flips its multiplexer. Patterns such as `0xF0 + 0x10 + 1`, top-bit overflow and all-ones with carry-in provoke both at once, and the exhaustive 8-bit sweep covers every combination of the two across the section boundary. Each result is judged against the arithmetic sum computed in the bench.

// File: rtl/csla_pkg.sv
package csla_pkg;
  localparam int unsigned DEF_WIDTH = 32;
  localparam int unsigned DEF_GRP   = 4;

  function automatic int unsigned sec_count(input int unsigned width, input int unsigned grp);
    return width / grp;
  endfunction
endpackage

// File: rtl/csla_la_group.sv
// Lookahead group: every carry is a flattened sum of products of G, P and the carry-in.
module csla_la_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W-1:0] gen;
  logic [W-1:0] prp;
  logic [W:0]   cy;

  assign gen = a & b;
  assign prp = a ^ b;

  always_comb begin
    cy[0] = ci;
    for (int i = 0; i < W; i++) begin
      logic acc;
      logic prod;
      acc  = gen[i];
      prod = prp[i];
      for (int j = i - 1; j >= 0; j--) begin
        acc  = acc | (prod & gen[j]);
        prod = prod & prp[j];
      end
      cy[i+1] = acc | (prod & ci);
    end
  end

  assign s  = prp ^ cy[W-1:0];
  assign co = cy[W];
endmodule

// File: rtl/csla_sel_section.sv
// One section: either a single lookahead group (lowest) or a duplicated pair with a select mux.
module csla_sel_section #(
  parameter int unsigned W   = 4,
  parameter bit          DUP = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co,
  output logic         co_if0,
  output logic         co_if1
);
  generate
    if (DUP) begin : g_dup
      logic [W-1:0] s0, s1;
      csla_la_group #(.W(W)) u_lo (.a(a), .b(b), .ci(1'b0), .s(s0), .co(co_if0));
      csla_la_group #(.W(W)) u_hi (.a(a), .b(b), .ci(1'b1), .s(s1), .co(co_if1));
      always_comb begin
        s  = ci ? s1 : s0;
        co = ci ? co_if1 : co_if0;
      end
    end else begin : g_single
      csla_la_group #(.W(W)) u_one (.a(a), .b(b), .ci(ci), .s(s), .co(co));
      assign co_if0 = co;
      assign co_if1 = co;
    end
  endgenerate
endmodule

// File: rtl/csla_adder.sv
module csla_adder #(
  parameter int unsigned WIDTH = csla_pkg::DEF_WIDTH,
  parameter int unsigned GRP   = csla_pkg::DEF_GRP
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             c_out
);
  localparam int unsigned NSEC = csla_pkg::sec_count(WIDTH, GRP);

  logic [NSEC:0]   sec_c;   // carry into each section, plus final carry
  logic [NSEC-1:0] cand0;   // section carry-out assuming incoming 0
  logic [NSEC-1:0] cand1;   // section carry-out assuming incoming 1

  assign sec_c[0] = c_in;   // R2: lowest section sees external carry directly

  generate
    for (genvar k = 0; k < NSEC; k++) begin : g_sec
      csla_sel_section #(.W(GRP), .DUP(k != 0)) u_sec (
        .a      (a_in[k*GRP +: GRP]),
        .b      (b_in[k*GRP +: GRP]),
        .ci     (sec_c[k]),
        .s      (sum_out[k*GRP +: GRP]),
        .co     (sec_c[k+1]),
        .co_if0 (cand0[k]),
        .co_if1 (cand1[k])
      );
    end
  endgenerate

  assign c_out = sec_c[NSEC];
endmodule

// File: rtl/csla_adder_chk.sv
module csla_adder_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned GRP   = 4,
  parameter int unsigned NSEC  = WIDTH / GRP
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             c_in,
  input logic [WIDTH-1:0] sum_out,
  input logic             c_out,
  input logic [NSEC:0]    sec_c,
  input logic [NSEC-1:0]  cand0,
  input logic [NSEC-1:0]  cand1
);
  always_comb begin
    logic [WIDTH:0] total;
    total = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in};
    a_r1_full_sum: assert ({c_out, sum_out} == total)
      else $error("R1 sum mismatch");
  end

  always_comb begin
    for (int k = 1; k <= NSEC; k++) begin
      logic [WIDTH:0] mask;
      logic [WIDTH:0] part;
      mask = ({{WIDTH{1'b0}}, 1'b1} << (k * GRP)) - 1'b1;
      part = ({1'b0, a_in} & mask) + ({1'b0, b_in} & mask) + {{WIDTH{1'b0}}, c_in};
      a_r4_section_carry: assert (sec_c[k] == part[k*GRP])
        else $error("R4 carry into section %0d wrong", k);
    end
  end

  always_comb begin
    for (int k = 0; k < NSEC; k++) begin
      a_r5_cand_order: assert (!(cand0[k] && !cand1[k]))
        else $error("R5 candidate carries out of order in section %0d", k);
      a_r5_own_carry: assert ((cand0[k] != cand1[k]) || (sec_c[k+1] == cand0[k]))
        else $error("R5 generated carry lost in section %0d", k);
    end
  end
endmodule

bind csla_adder csla_adder_chk #(.WIDTH(WIDTH), .GRP(GRP)) u_chk (
  .a_in(a_in), .b_in(b_in), .c_in(c_in), .sum_out(sum_out), .c_out(c_out),
  .sec_c(sec_c), .cand0(cand0), .cand1(cand1)
);

// File: tb/csla_adder_test.sv
`timescale 1ns/1ps
module csla_adder_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;  // 100 MHz

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [31:0] a = '0, b = '0;
  logic        ci = 1'b0;
  logic [31:0] s;
  logic        co;

  logic [7:0] sa = '0, sb = '0;
  logic       sci = 1'b0;
  logic [7:0] ss;
  logic       sco;

  csla_adder #(.WIDTH(32), .GRP(4)) uut (
    .a_in(a), .b_in(b), .c_in(ci), .sum_out(s), .c_out(co));

  csla_adder #(.WIDTH(8), .GRP(4)) uut_small (
    .a_in(sa), .b_in(sb), .c_in(sci), .sum_out(ss), .c_out(sco));

  task automatic chk32(input logic [31:0] x, input logic [31:0] y, input logic c,
                       input string req);
    logic [32:0] want;
    a = x; b = y; ci = c;
    #1;  // R8: settles in the same step, no clock edge needed
    want = {1'b0, x} + {1'b0, y} + {32'd0, c};
    total++;
    if ({co, s} !== want) begin
      bad++;
      $display("FAIL %s: a=%h b=%h ci=%0d got %h expected %h", req, x, y, c, {co, s}, want);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2;
    // R8: reset-free state with zero inputs
    chk32(32'h0, 32'h0, 1'b0, "R8 initial zero");
    // R2
    chk32(32'h0, 32'h0, 1'b1, "R2 carry-in only");
    chk32(32'h0, 32'h0, 1'b0, "R2 carry-in cleared");
    // R3
    chk32(32'hFFFF_FFFF, 32'h0, 1'b1, "R3 full propagate");
    chk32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R3 all ones both");
    chk32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R3 all ones no cin");
    // R4
    chk32(32'h0000_000F, 32'h0000_0001, 1'b0, "R4 boundary select");
    chk32(32'h0FFF_FFFF, 32'h0000_0001, 1'b0, "R4 long select chain");
    chk32(32'h0000_00FF, 32'h0, 1'b1, "R4 two-section propagate");
    // R5
    chk32(32'h0000_00F0, 32'h0000_0010, 1'b1, "R5 own carry plus cin");
    chk32(32'h8000_0000, 32'h8000_0000, 1'b0, "R5 top generate");
    chk32(32'h0880_0880, 32'h0880_0880, 1'b1, "R5 mid generates");
    // R6
    chk32(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R6 alternating cin0");
    chk32(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R6 alternating cin1");
    chk32(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1, "R6 alternating doubled");
    chk32(32'h5555_5555, 32'h5555_5555, 1'b0, "R6 alternating low doubled");
    // R1: random vectors
    for (int n = 0; n < 2000; n++) begin
      chk32($urandom, $urandom, 1'($urandom), "R1 random");
    end
    // R7: exhaustive sweep of the small configuration
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int c = 0; c < 2; c++) begin
          logic [8:0] want;
          sa = 8'(x); sb = 8'(y); sci = 1'(c);
          #1;
          want = 9'(x) + 9'(y) + 9'(c);
          total++;
          if ({sco, ss} !== want) begin
            bad++;
            $display("FAIL R7 small: a=%h b=%h ci=%0d got %h expected %h",
                     sa, sb, sci, {sco, ss}, want);
          end
        end
      end
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule